// File: doc/BRIEF.md
# Base-Bound Protection and Privilege Unit

This unit sits between an instruction pipeline and its memory port and enforces process isolation with a pair of limit registers. When the hart runs in user mode, every data access is tested against a base and a bound. A build parameter chooses one of two variants. The check variant passes the address through unchanged if it lies in the inclusive window. The relocation variant adds the unsigned address to the base and sends the sum out as the physical address, provided the sum does not pass the bound. Accesses made in supervisor mode bypass the test.

The unit also holds the privilege state: a mode bit, an exception-enable bit, a saved PC and a saved mode. Supervisor code writes the limit registers, the mode bit and the exception-enable bit through a small write port. User code may read them, but any user write is refused. A system-call request, or a fault taken while exceptions are enabled, saves the PC and the mode, enters supervisor mode and tells the pipeline to load a fixed vector. A return request restores both.

Top module: `priv_guard`

## Requirements
- R1: With RELOCATE=0, a user-mode access (acc_req=1) is forwarded (acc_go=1, acc_phys=acc_addr) exactly when base <= acc_addr <= bound, both bounds inclusive.
- R2: With RELOCATE=1, a user-mode access is forwarded with acc_phys = base + acc_addr exactly when that sum, computed one bit wider than the address, is <= bound. A carry out of the address width is therefore illegal.
- R3: In supervisor mode (mode_sup=1), acc_go equals acc_req and acc_phys equals acc_addr, whatever the limits hold.
- R4: After reset, mode_sup=1, exceptions are disabled, base reads 0 and bound reads all ones.
- R5: rd_data returns, for rd_sel 0/1/2/3, the base, the bound, the mode bit (1 = supervisor) and the exception-enable bit, in any mode. The same wr_sel codes select the write target, and a mode or enable write uses wr_data bit 0. A wr_req made in user mode changes none of these values.
- R6: An illegal user access or a user wr_req is a violation. The access is always suppressed (acc_go=0). The fault output pulses for one cycle, in the cycle after the violation, only when the exception-enable bit is 1. When that bit is 0, the mode and the PC are left unchanged.
- R7: When no fault is taken, sys_call saves pc_in and the current mode and sets mode_sup=1. In the next cycle, pc_load=1 and pc_next=SYS_VEC.
- R8: A fault taken with exceptions enabled saves pc_in and the current mode and sets mode_sup=1. In the next cycle, pc_load=1 and pc_next=FLT_VEC.
- R9: sys_ret in supervisor mode restores the saved mode and gives pc_load=1 with pc_next equal to the saved PC in the next cycle. sys_ret in user mode has no effect.
- R10: Within one cycle a taken fault wins over sys_call, which wins over sys_ret. Any of these overrides a supervisor write to the mode bit in the same cycle. Writes to the other registers still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Data access request |
| acc_addr | input | AW | Access address from the pipeline |
| acc_go | output | 1 | Access forwarded to memory |
| acc_phys | output | AW | Address sent to memory |
| wr_req | input | 1 | Privileged register write |
| wr_sel | input | 2 | Write target: 0 base, 1 bound, 2 mode, 3 exception enable |
| wr_data | input | AW | Write value |
| rd_sel | input | 2 | Read target, same codes as wr_sel |
| rd_data | output | AW | Read value |
| pc_in | input | PCW | PC of the current instruction |
| sys_call | input | 1 | System-call request |
| sys_ret | input | 1 | Return request |
| mode_sup | output | 1 | 1 = supervisor mode |
| pc_load | output | 1 | Pipeline must load pc_next |
| pc_next | output | PCW | Redirect target |
| fault | output | 1 | One-cycle protection fault pulse |

## Verification
The hardest cases to reach are the same-cycle collisions: a fault alongside a system call, a system call alongside a mode write, and a relocation sum that carries out of the address width. Each needs the mode, the limits and the enable bit set up first, with the right prior mode saved. The directed stimulus uses traps and returns to move between modes, then lines up each collision on one edge. A long random phase follows, with requests biased towards rare calls and writes. A behavioural model of both variants is compared on every clock.

// File: rtl/pg_pkg.sv
package pg_pkg;
   typedef enum logic [1:0] {
      SEL_BASE  = 2'd0,
      SEL_BOUND = 2'd1,
      SEL_MODE  = 2'd2,
      SEL_EXC   = 2'd3
   } pg_sel_e;
endpackage

// File: rtl/pg_range.sv
module pg_range #(
   parameter int AW       = 16,
   parameter bit RELOCATE = 1'b0
) (
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] bound_i,
   input  logic [AW-1:0] addr_i,
   output logic          ok_o,
   output logic [AW-1:0] phys_o
);
   localparam int SW = AW + 1;

   generate
      if (RELOCATE) begin : g_reloc
         logic [SW-1:0] sum;
         assign sum    = {1'b0, base_i} + {1'b0, addr_i};
         assign ok_o   = (sum <= {1'b0, bound_i});
         assign phys_o = sum[AW-1:0];
      end else begin : g_check
         assign ok_o   = (addr_i >= base_i) && (addr_i <= bound_i);
         assign phys_o = addr_i;
      end
   endgenerate
endmodule

// File: rtl/pg_regs.sv
module pg_regs
   import pg_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [1:0]    wsel_i,
   input  logic [AW-1:0] wdata_i,
   input  logic [1:0]    rsel_i,
   input  logic          sup_i,
   output logic [AW-1:0] base_o,
   output logic [AW-1:0] bound_o,
   output logic          exc_o,
   output logic [AW-1:0] rdata_o
);
   localparam int PADW = AW - 1;

   logic          wen;
   logic [AW-1:0] base_q, bound_q;
   logic          exc_q;

   assign wen = wr_i && sup_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         bound_q <= '1;
         exc_q   <= 1'b0;
      end else if (wen) begin
         case (pg_sel_e'(wsel_i))
            SEL_BASE:  base_q  <= wdata_i;
            SEL_BOUND: bound_q <= wdata_i;
            SEL_EXC:   exc_q   <= wdata_i[0];
            default:   ;
         endcase
      end
   end

   always_comb begin
      case (pg_sel_e'(rsel_i))
         SEL_BASE:  rdata_o = base_q;
         SEL_BOUND: rdata_o = bound_q;
         SEL_MODE:  rdata_o = {{PADW{1'b0}}, sup_i};
         default:   rdata_o = {{PADW{1'b0}}, exc_q};
      endcase
   end

   assign base_o  = base_q;
   assign bound_o = bound_q;
   assign exc_o   = exc_q;

   // R5
   user_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sup_i && wr_i) |=> (base_q == $past(base_q)) && (bound_q == $past(bound_q))
                           && (exc_q == $past(exc_q)));
endmodule

// File: rtl/pg_trap.sv
module pg_trap #(
   parameter int             PCW     = 16,
   parameter logic [PCW-1:0] SYS_VEC = '0,
   parameter logic [PCW-1:0] FLT_VEC = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           flt_take_i,
   input  logic           call_i,
   input  logic           ret_i,
   input  logic           mode_wr_i,
   input  logic           mode_wdata_i,
   input  logic [PCW-1:0] pc_i,
   output logic           sup_o,
   output logic           load_o,
   output logic [PCW-1:0] next_o,
   output logic           fault_o
);
   logic           sup_q, prev_q, load_q, fault_q;
   logic [PCW-1:0] epc_q, next_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sup_q   <= 1'b1;
         prev_q  <= 1'b1;
         epc_q   <= '0;
         next_q  <= '0;
         load_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         load_q  <= 1'b0;
         fault_q <= 1'b0;
         if (flt_take_i) begin
            epc_q   <= pc_i;
            prev_q  <= sup_q;
            sup_q   <= 1'b1;
            load_q  <= 1'b1;
            next_q  <= FLT_VEC;
            fault_q <= 1'b1;
         end else if (call_i) begin
            epc_q  <= pc_i;
            prev_q <= sup_q;
            sup_q  <= 1'b1;
            load_q <= 1'b1;
            next_q <= SYS_VEC;
         end else if (ret_i && sup_q) begin
            sup_q  <= prev_q;
            load_q <= 1'b1;
            next_q <= epc_q;
         end else if (mode_wr_i) begin
            sup_q <= mode_wdata_i;
         end
      end
   end

   assign sup_o   = sup_q;
   assign load_o  = load_q;
   assign next_o  = next_q;
   assign fault_o = fault_q;

   // R7
   syscall_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && !flt_take_i) |=> load_o && (next_o == SYS_VEC) && sup_o);
   // R8
   fault_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flt_take_i |=> load_o && fault_o && (next_o == FLT_VEC) && sup_o);
   // R9
   ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && sup_q && !call_i && !flt_take_i) |=> load_o && (next_o == $past(epc_q))
                                                     && (sup_o == $past(prev_q)));
endmodule

// File: rtl/priv_guard.sv
module priv_guard
   import pg_pkg::*;
#(
   parameter int             AW       = 16,
   parameter int             PCW      = 16,
   parameter bit             RELOCATE = 1'b0,
   parameter logic [PCW-1:0] SYS_VEC  = 16'h0040,
   parameter logic [PCW-1:0] FLT_VEC  = 16'h0080
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           acc_req,
   input  logic [AW-1:0]  acc_addr,
   output logic           acc_go,
   output logic [AW-1:0]  acc_phys,
   input  logic           wr_req,
   input  logic [1:0]     wr_sel,
   input  logic [AW-1:0]  wr_data,
   input  logic [1:0]     rd_sel,
   output logic [AW-1:0]  rd_data,
   input  logic [PCW-1:0] pc_in,
   input  logic           sys_call,
   input  logic           sys_ret,
   output logic           mode_sup,
   output logic           pc_load,
   output logic [PCW-1:0] pc_next,
   output logic           fault
);
   generate
      if (AW < 2) begin : g_bad_aw
         $error("priv_guard: AW must be at least 2");
      end
      if (PCW < 2) begin : g_bad_pcw
         $error("priv_guard: PCW must be at least 2");
      end
   endgenerate

   logic [AW-1:0] base, bound, phys;
   logic          exc_en, in_range, sup;
   logic          viol, flt_take, mode_wr;

   pg_range #(.AW(AW), .RELOCATE(RELOCATE)) u_range (
      .base_i (base),
      .bound_i(bound),
      .addr_i (acc_addr),
      .ok_o   (in_range),
      .phys_o (phys)
   );

   pg_regs #(.AW(AW)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (wr_req),
      .wsel_i (wr_sel),
      .wdata_i(wr_data),
      .rsel_i (rd_sel),
      .sup_i  (sup),
      .base_o (base),
      .bound_o(bound),
      .exc_o  (exc_en),
      .rdata_o(rd_data)
   );

   assign viol     = !sup && ((acc_req && !in_range) || wr_req);
   assign flt_take = viol && exc_en;
   assign mode_wr  = sup && wr_req && (wr_sel == SEL_MODE);

   pg_trap #(.PCW(PCW), .SYS_VEC(SYS_VEC), .FLT_VEC(FLT_VEC)) u_trap (
      .clk         (clk),
      .rst_n       (rst_n),
      .flt_take_i  (flt_take),
      .call_i      (sys_call),
      .ret_i       (sys_ret),
      .mode_wr_i   (mode_wr),
      .mode_wdata_i(wr_data[0]),
      .pc_i        (pc_in),
      .sup_o       (sup),
      .load_o      (pc_load),
      .next_o      (pc_next),
      .fault_o     (fault)
   );

   assign acc_go   = acc_req && (sup || in_range);
   assign acc_phys = sup ? acc_addr : phys;
   assign mode_sup = sup;

   // R3
   sup_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sup |-> (acc_go == acc_req) && (acc_phys == acc_addr));
   // R6
   fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault);
   // R6
   fault_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $past(exc_en) && !$past(mode_sup));
   // R1
   generate
      if (!RELOCATE) begin : g_chk_asrt
         window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_go && !mode_sup) |-> (acc_addr >= base) && (acc_addr <= bound));
      end
   endgenerate
endmodule

// File: tb/priv_guard_bench.sv
module priv_guard_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW  = 16;
   localparam int PCW = 16;
   localparam logic [PCW-1:0] SYSV = 16'h0040;
   localparam logic [PCW-1:0] FLTV = 16'h0080;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic           a_req = 0, w_req = 0, call = 0, ret = 0;
   logic [AW-1:0]  a_addr = 0, w_dat = 0;
   logic [1:0]     w_sel = 0, r_sel = 0;
   logic [PCW-1:0] pc = 0;

   logic           go [2];
   logic [AW-1:0]  phys [2];
   logic [AW-1:0]  rdat [2];
   logic           sup [2];
   logic           load [2];
   logic [PCW-1:0] nxt [2];
   logic           flt [2];

   priv_guard #(.AW(AW), .PCW(PCW), .RELOCATE(1'b0), .SYS_VEC(SYSV), .FLT_VEC(FLTV)) u_priv_guard (
      .clk(clk), .rst_n(rst_n), .acc_req(a_req), .acc_addr(a_addr), .acc_go(go[0]),
      .acc_phys(phys[0]), .wr_req(w_req), .wr_sel(w_sel), .wr_data(w_dat), .rd_sel(r_sel),
      .rd_data(rdat[0]), .pc_in(pc), .sys_call(call), .sys_ret(ret), .mode_sup(sup[0]),
      .pc_load(load[0]), .pc_next(nxt[0]), .fault(flt[0]));

   priv_guard #(.AW(AW), .PCW(PCW), .RELOCATE(1'b1), .SYS_VEC(SYSV), .FLT_VEC(FLTV)) u_priv_guard_rel (
      .clk(clk), .rst_n(rst_n), .acc_req(a_req), .acc_addr(a_addr), .acc_go(go[1]),
      .acc_phys(phys[1]), .wr_req(w_req), .wr_sel(w_sel), .wr_data(w_dat), .rd_sel(r_sel),
      .rd_data(rdat[1]), .pc_in(pc), .sys_call(call), .sys_ret(ret), .mode_sup(sup[1]),
      .pc_load(load[1]), .pc_next(nxt[1]), .fault(flt[1]));

   // behavioural reference state, index 0 = window check, 1 = relocation
   int m_base [2], m_bound [2], m_epc [2], m_nxt [2];
   bit m_exc [2], m_sup [2], m_prev [2], m_load [2], m_flt [2];
   int n_cmp = 0, n_bad = 0;

   function automatic bit legal(int v, int addr);
      if (v == 0) return (addr >= m_base[v]) && (addr <= m_bound[v]);
      return (m_base[v] + addr) <= m_bound[v];
   endfunction

   always @(posedge clk) begin
      for (int v = 0; v < 2; v++) begin
         if (!rst_n) begin
            m_base[v] = 0; m_bound[v] = 32'hFFFF; m_exc[v] = 0; m_sup[v] = 1;
            m_prev[v] = 1; m_epc[v] = 0; m_nxt[v] = 0; m_load[v] = 0; m_flt[v] = 0;
         end else begin
            bit s, take;
            s = m_sup[v];
            take = !s && ((a_req && !legal(v, int'(a_addr))) || w_req) && m_exc[v];
            m_load[v] = 0; m_flt[v] = 0;
            if (s && w_req) begin
               if (w_sel == 2'd0) m_base[v] = int'(w_dat);
               if (w_sel == 2'd1) m_bound[v] = int'(w_dat);
               if (w_sel == 2'd3) m_exc[v] = w_dat[0];
            end
            if (take) begin
               m_epc[v] = int'(pc); m_prev[v] = s; m_sup[v] = 1; m_load[v] = 1;
               m_nxt[v] = int'(FLTV); m_flt[v] = 1;
            end else if (call) begin
               m_epc[v] = int'(pc); m_prev[v] = s; m_sup[v] = 1; m_load[v] = 1;
               m_nxt[v] = int'(SYSV);
            end else if (ret && s) begin
               m_sup[v] = m_prev[v]; m_load[v] = 1; m_nxt[v] = m_epc[v];
            end else if (s && w_req && w_sel == 2'd2) begin
               m_sup[v] = w_dat[0];
            end
         end
      end
   end

   task automatic chk(string tag, int v, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s variant %0d %s: actual %h expected %h", tag, v, what, act, exp);
      end
   endtask

   task automatic compare_all();
      for (int v = 0; v < 2; v++) begin
         string t_acc;
         int ex_rd, ex_go, ex_ph;
         bit ok;
         ok = legal(v, int'(a_addr));
         if (m_sup[v]) begin
            t_acc = "R3"; ex_go = a_req; ex_ph = int'(a_addr);
         end else begin
            t_acc = (v == 0) ? "R1" : "R2";
            ex_go = a_req && ok;
            ex_ph = (v == 0) ? int'(a_addr) : ((m_base[v] + int'(a_addr)) & 32'hFFFF);
         end
         chk(t_acc, v, "acc_go", int'(go[v]), ex_go);
         if (ex_go) chk(t_acc, v, "acc_phys", int'(phys[v]), ex_ph);
         case (r_sel)
            2'd0: ex_rd = m_base[v];
            2'd1: ex_rd = m_bound[v];
            2'd2: ex_rd = int'(m_sup[v]);
            default: ex_rd = int'(m_exc[v]);
         endcase
         chk("R5", v, "rd_data", int'(rdat[v]), ex_rd);
         chk("R6", v, "fault", int'(flt[v]), int'(m_flt[v]));
         chk("R9", v, "mode_sup", int'(sup[v]), int'(m_sup[v]));
         chk("R7", v, "pc_load", int'(load[v]), int'(m_load[v]));
         if (m_load[v]) begin
            if (m_nxt[v] == int'(FLTV)) chk("R8", v, "pc_next", int'(nxt[v]), m_nxt[v]);
            else if (m_nxt[v] == int'(SYSV)) chk("R7", v, "pc_next", int'(nxt[v]), m_nxt[v]);
            else chk("R9", v, "pc_next", int'(nxt[v]), m_nxt[v]);
         end
      end
   endtask

   task automatic cyc();
      #1 compare_all();
      @(negedge clk);
   endtask

   task automatic idle();
      a_req = 0; w_req = 0; call = 0; ret = 0;
   endtask

   task automatic wr(input logic [1:0] s, input logic [AW-1:0] d);
      idle(); w_req = 1; w_sel = s; w_dat = d; cyc(); idle();
   endtask

   task automatic access(input logic [AW-1:0] a);
      idle(); a_req = 1; a_addr = a; cyc(); idle();
   endtask

   task automatic do_call(input logic [PCW-1:0] p);
      idle(); call = 1; pc = p; cyc(); idle();
   endtask

   task automatic do_ret();
      idle(); ret = 1; cyc(); idle();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R4: reset values read through the register port
      for (int s = 0; s < 4; s++) begin
         r_sel = 2'(s);
         #1;
         for (int v = 0; v < 2; v++) begin
            chk("R4", v, "reset read", int'(rdat[v]),
                (s == 0) ? 0 : (s == 1) ? 32'hFFFF : (s == 2) ? 1 : 0);
            chk("R4", v, "reset mode", int'(sup[v]), 1);
         end
         @(negedge clk);
      end
      r_sel = 2'd0;
      // supervisor setup, then a supervisor access outside the window (R3)
      wr(2'd0, 16'h1000); wr(2'd1, 16'h1FFF); wr(2'd3, 16'h0001);
      access(16'h0005);
      pc = 16'h0100;
      wr(2'd2, 16'h0000);
      // R1/R2 user accesses at and around the limits
      access(16'h1000); do_ret();
      access(16'h1FFF); do_ret();
      access(16'h0FFF); do_ret();
      access(16'h2000); do_ret();
      access(16'h0000); do_ret();
      // R5 user write refused
      r_sel = 2'd1;
      wr(2'd1, 16'h0003); do_ret();
      r_sel = 2'd0;
      wr(2'd0, 16'h0ABC); do_ret();
      // R7 / R9 system call and return
      do_call(16'h0234); do_ret();
      // R6 with exceptions disabled: suppressed, no fault, no trap
      do_call(16'h0300); wr(2'd3, 16'h0000); do_ret();
      access(16'h3000); access(16'h3001);
      do_call(16'h0310); wr(2'd3, 16'h0001);
      // R10 call collides with a mode write in supervisor
      idle(); call = 1; pc = 16'h0320; w_req = 1; w_sel = 2'd2; w_dat = 16'h0000; cyc(); idle();
      for (int v = 0; v < 2; v++) chk("R10", v, "mode after call+write", int'(sup[v]), 1);
      wr(2'd2, 16'h0000);
      // R10 fault wins over a system call in the same cycle
      idle(); call = 1; pc = 16'h0330; a_req = 1; a_addr = 16'h3000; cyc(); idle();
      for (int v = 0; v < 2; v++) chk("R10", v, "fault beats call", int'(nxt[v]), int'(FLTV));
      do_ret();
      // R2 carry out of the relocation sum
      do_call(16'h0400); wr(2'd0, 16'hF000); wr(2'd1, 16'hFFFF); wr(2'd2, 16'h0000);
      access(16'h2000);
      chk("R2", 1, "carry fault", int'(flt[1]), 1);
      do_ret();
      access(16'h0FFF); do_ret();
      // random phase
      for (int i = 0; i < 4000; i++) begin
         a_req  = ($urandom_range(0, 3) != 0);
         a_addr = 16'($urandom());
         w_req  = ($urandom_range(0, 7) == 0);
         w_sel  = 2'($urandom());
         w_dat  = ($urandom_range(0, 1) == 0) ? 16'($urandom()) : 16'($urandom_range(0, 1));
         r_sel  = 2'($urandom());
         pc     = 16'($urandom());
         call   = ($urandom_range(0, 15) == 0);
         ret    = ($urandom_range(0, 5) == 0);
         cyc();
      end
      idle();
      cyc();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule